// File: doc/BRIEF.md
# SDRAM Bank Open/Idle Tracker

This block sits beside the command issuer of an SDRAM controller and follows the commands the controller sends to the memory. From the command stream it keeps, for every bank, whether a row is open and whether the bank has finished precharge recovery. The commands it follows are activate, read, write, precharge and burst stop. Address bit 10 travels with each command. The command scheduler reads the per-bank flags to decide which banks may take an activate, and which may take a read or a write.

On a read or write, bit 10 asks for the addressed bank to close by itself once the burst ends. The request applies to that one command only, and it has no effect when the burst mode is full-page. On a precharge, bit 10 chooses between closing every bank and closing only the bank on the bank-select lines. After any close, a recovery window of `T_RP` cycles keeps the bank from taking a new activate. A command that breaks these rules raises a one-cycle error pulse and changes no state. Burst length and recovery time are parameters.

Top module: `sdr_bank_tracker`

## Requirements
- R1: After reset every bank reads idle (`bank_open` all 0), every bank reads ready (`bank_ready` all 1) and `cmd_err` is 0.
- R2: An activate (cmd_op 1) to a ready bank sets that bank's `bank_open` bit from the clock edge that takes it. `bank_ready` is low for any bank whose row is open.
- R3: A precharge (cmd_op 4) with a10 = 0 closes only the bank on `cmd_bank`, and the other banks keep their state. A precharge to a bank that is already idle changes nothing, and its `bank_ready` stays high.
- R4: A precharge with a10 = 1 closes every open bank, whatever value is on `cmd_bank`.
- R5: When a bank closes at edge p, its `bank_ready` is low after edges p through p+T_RP-1 and high after edge p+T_RP.
- R6: A read (cmd_op 2) or write (cmd_op 3) with a10 = 1 at edge k, not in full-page mode, closes its bank at edge k+BURST_LEN. Recovery then follows as in R5.
- R7: A read or write with a10 = 0 leaves the row open. The automatic close does not carry over, so a later read without a10 leaves the row open too.
- R8: When `cfg_full_page` is 1, a10 on a read or write is ignored and the row stays open until an explicit precharge.
- R9: A burst stop (cmd_op 5), or a new read or write, cuts short the running burst and drops its pending automatic close, so the row stays open.
- R10: A read or write to a bank that is not open, or an activate to a bank that is not ready, raises `cmd_err` for exactly one cycle after the edge that takes it and leaves all bank state unchanged. A bank whose automatic close falls on the same edge counts as not open.
- R11: An explicit precharge that closes the bank of a running burst ends that burst. A pending automatic close then never fires on a row opened later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop |
| cmd_bank | input | 2 | Bank addressed by the command |
| cmd_a10 | input | 1 | Address bit 10: auto close on read/write, all banks on precharge |
| cfg_full_page | input | 1 | Burst mode is full-page; static while bursts run |
| bank_open | output | 4 | Per-bank row-open flag |
| bank_ready | output | 4 | Per-bank flag: idle and recovery complete, may be activated |
| cmd_err | output | 1 | One-cycle pulse after an illegal command |

## Verification
On every cycle the assertions check four things. A bank in recovery never opens. A bank that has just closed never reads ready. A precharge to all banks leaves none open. An access to a non-open bank always flags an error. They also check that a burst stop ends burst tracking and that no automatic close fires in full-page mode. The directed scenarios are the only way to show the exact close edge at k+BURST_LEN and the exact length of the recovery window. They also show that pending closes are dropped on truncation, and that an explicit precharge in mid-burst keeps a later row from closing.

// File: rtl/sdr_bank_pkg.sv
package sdr_bank_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_BST = 3'd5
  } sdr_op_e;
endpackage

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int T_RP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic close_req,
  output logic is_open,
  output logic is_ready
);
  localparam int RW = $clog2(T_RP + 1);

  logic          open_q;
  logic [RW-1:0] rcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      rcnt_q <= '0;
    end else if (close_req && open_q) begin
      open_q <= 1'b0;
      rcnt_q <= RW'(T_RP);
    end else if (open_req) begin
      open_q <= 1'b1;
    end else if (rcnt_q != '0) begin
      rcnt_q <= rcnt_q - 1'b1;
    end
  end

  assign is_open  = open_q;
  assign is_ready = !open_q && (rcnt_q == '0);

  // R3 / R5: no activate may land while recovery is counting
  a_r5_no_open_in_trp: assert property (@(posedge clk) disable iff (rst)
    (!open_q && rcnt_q != '0) |=> !open_q);
  // R5: a freshly closed bank is never ready on the same cycle
  a_r5_closed_not_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(open_q) |-> !is_ready);
endmodule

// File: rtl/sdr_burst_track.sv
module sdr_burst_track #(
  parameter int BURST_LEN = 8,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_page,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              start_ap,
  input  logic              stop,
  input  logic              kill,
  output logic              active,
  output logic [BANK_W-1:0] cur_bank,
  output logic              fire
);
  localparam int CW = $clog2(BURST_LEN + 1);

  logic              act_q;
  logic              ap_q;
  logic [CW-1:0]     cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic              done;

  assign done = act_q && !full_page && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      cnt_q  <= '0;
      bank_q <= '0;
    end else begin
      if (done)
        act_q <= 1'b0;
      else if (act_q && !full_page)
        cnt_q <= cnt_q - 1'b1;
      if (stop || kill)
        act_q <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        bank_q <= start_bank;
        ap_q   <= start_ap && !full_page;
        cnt_q  <= CW'(BURST_LEN - 1);
      end
    end
  end

  assign active   = act_q;
  assign cur_bank = bank_q;
  assign fire     = done && ap_q;

  // R9: a burst stop with no new access leaves nothing running
  a_r9_stop_ends_burst: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !act_q);
  // R8: full-page mode (held static while bursts run) never auto-closes
  a_r8_no_fire_full_page: assert property (@(posedge clk) disable iff (rst)
    full_page |-> !fire);
endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
  import sdr_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 8,
  parameter int T_RP      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic                         cmd_a10,
  input  logic                         cfg_full_page,
  output logic [NUM_BANKS-1:0]         bank_open,
  output logic [NUM_BANKS-1:0]         bank_ready,
  output logic                         cmd_err
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  sdr_op_e              op;
  logic                 is_act, is_rw, is_pre, is_bst;
  logic [NUM_BANKS-1:0] sel_vec, fire_vec, open_eff, close_vec, open_vec;
  logic                 rw_ok, act_ok, kill, err_q;
  logic                 b_active, b_fire;
  logic [BANK_W-1:0]    b_bank;

  assign op     = sdr_op_e'(cmd_op);
  assign is_act = cmd_valid && (op == OP_ACT);
  assign is_rw  = cmd_valid && (op == OP_RD || op == OP_WR);
  assign is_pre = cmd_valid && (op == OP_PRE);
  assign is_bst = cmd_valid && (op == OP_BST);

  assign sel_vec  = NUM_BANKS'(1) << cmd_bank;
  assign fire_vec = b_fire ? (NUM_BANKS'(1) << b_bank) : '0;
  assign open_eff = bank_open & ~fire_vec;

  assign rw_ok  = is_rw && open_eff[cmd_bank];
  assign act_ok = is_act && bank_ready[cmd_bank];
  assign kill   = is_pre && b_active && (cmd_a10 || cmd_bank == b_bank);

  assign close_vec = fire_vec | (is_pre ? (cmd_a10 ? '1 : sel_vec) : '0);
  assign open_vec  = act_ok ? sel_vec : '0;

  sdr_burst_track #(.BURST_LEN(BURST_LEN), .BANK_W(BANK_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .full_page  (cfg_full_page),
    .start      (rw_ok),
    .start_bank (cmd_bank),
    .start_ap   (cmd_a10),
    .stop       (is_bst),
    .kill       (kill),
    .active     (b_active),
    .cur_bank   (b_bank),
    .fire       (b_fire)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdr_bank_slot #(.T_RP(T_RP)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .open_req  (open_vec[b]),
      .close_req (close_vec[b]),
      .is_open   (bank_open[b]),
      .is_ready  (bank_ready[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else
      err_q <= (is_rw && !open_eff[cmd_bank]) || (is_act && !bank_ready[cmd_bank]);
  end
  assign cmd_err = err_q;

  // R2: an activate to a ready bank opens it
  a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
    (is_act && bank_ready[cmd_bank]) |=> bank_open[$past(cmd_bank)]);
  // R4: precharge with bit 10 leaves no bank open
  a_r4_pre_all_closes: assert property (@(posedge clk) disable iff (rst)
    (is_pre && cmd_a10) |=> (bank_open == '0));
  // R10: access to a bank that is not open is flagged
  a_r10_err_idle_access: assert property (@(posedge clk) disable iff (rst)
    (is_rw && !bank_open[cmd_bank]) |=> cmd_err);
endmodule

// File: tb/sim_sdr_bank_tracker.sv
module sim_sdr_bank_tracker;
  localparam int BL  = 8;
  localparam int TRP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_a10 = 1'b0;
  logic       cfg_full_page = 1'b0;
  logic [3:0] bank_open, bank_ready;
  logic       cmd_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sdr_bank_tracker #(.NUM_BANKS(4), .BURST_LEN(BL), .T_RP(TRP)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cfg_full_page(cfg_full_page),
    .bank_open(bank_open), .bank_ready(bank_ready), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] bank, input logic a10);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_a10 = a10;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = 2'd0; cmd_a10 = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 open after reset", bank_open, 0);
    chk("R1 ready after reset", bank_ready, 15);
    chk("R1 err after reset", cmd_err, 0);
  endtask

  task automatic t_single_pre;
    cmd(3'd1, 2'd0, 1'b0);
    cmd(3'd1, 2'd2, 1'b0);
    chk("R2 open after activates", bank_open, 5);
    chk("R2 ready of open banks low", bank_ready, 10);
    cmd(3'd4, 2'd0, 1'b0);
    chk("R3 single precharge", bank_open, 4);
    chk("R5 not ready right after close", bank_ready[0], 0);
    tick(TRP - 1);
    chk("R5 not ready at end of window", bank_ready[0], 0);
    tick(1);
    chk("R5 ready after window", bank_ready[0], 1);
    cmd(3'd4, 2'd1, 1'b0);
    chk("R3 idle precharge keeps ready", bank_ready[1], 1);
    chk("R3 idle precharge keeps others", bank_open, 4);
    cmd(3'd1, 2'd3, 1'b0);
    cmd(3'd4, 2'd1, 1'b1);
    chk("R4 all-bank precharge", bank_open, 0);
    tick(TRP);
    chk("R4 all ready after window", bank_ready, 15);
  endtask

  task automatic t_autopre;
    cmd(3'd1, 2'd1, 1'b0);
    cmd(3'd2, 2'd1, 1'b1);
    tick(BL - 1);
    chk("R6 open until burst end", bank_open[1], 1);
    tick(1);
    chk("R6 closed at k+BURST_LEN", bank_open[1], 0);
    chk("R6 recovery after auto close", bank_ready[1], 0);
    tick(TRP);
    chk("R6 ready after auto close", bank_ready[1], 1);
  endtask

  task automatic t_nonpersist;
    cmd(3'd1, 2'd3, 1'b0);
    cmd(3'd3, 2'd3, 1'b0);
    tick(BL + 2);
    chk("R7 write without a10 keeps row", bank_open[3], 1);
    cmd(3'd2, 2'd3, 1'b0);
    tick(BL + 2);
    chk("R7 second read stays open", bank_open[3], 1);
    cmd(3'd4, 2'd0, 1'b1);
    tick(TRP);
  endtask

  task automatic t_fullpage;
    cfg_full_page = 1'b1;
    cmd(3'd1, 2'd0, 1'b0);
    cmd(3'd2, 2'd0, 1'b1);
    tick(BL + 4);
    chk("R8 full-page ignores a10", bank_open[0], 1);
    cmd(3'd5, 2'd0, 1'b0);
    tick(2);
    chk("R8 full-page open after stop", bank_open[0], 1);
    cmd(3'd4, 2'd0, 1'b1);
    tick(TRP);
    cfg_full_page = 1'b0;
  endtask

  task automatic t_truncate;
    cmd(3'd1, 2'd2, 1'b0);
    cmd(3'd2, 2'd2, 1'b1);
    tick(2);
    cmd(3'd5, 2'd0, 1'b0);
    tick(BL + 2);
    chk("R9 stop drops auto close", bank_open[2], 1);
    cmd(3'd3, 2'd2, 1'b1);
    tick(2);
    cmd(3'd2, 2'd2, 1'b0);
    tick(BL + 2);
    chk("R9 new access drops auto close", bank_open[2], 1);
    cmd(3'd4, 2'd0, 1'b1);
    tick(TRP);
  endtask

  task automatic t_errors;
    cmd(3'd2, 2'd0, 1'b0);
    chk("R10 read to idle bank flags", cmd_err, 1);
    chk("R10 no state change on bad read", bank_open, 0);
    tick(1);
    chk("R10 error is one cycle", cmd_err, 0);
    cmd(3'd1, 2'd0, 1'b0);
    cmd(3'd4, 2'd0, 1'b0);
    cmd(3'd1, 2'd0, 1'b0);
    chk("R10 activate in recovery flags", cmd_err, 1);
    chk("R10 bank stays closed", bank_open[0], 0);
    tick(TRP);
    cmd(3'd1, 2'd1, 1'b0);
    cmd(3'd1, 2'd1, 1'b0);
    chk("R10 activate to open bank flags", cmd_err, 1);
    cmd(3'd4, 2'd0, 1'b1);
    tick(TRP);
  endtask

  task automatic t_kill;
    cmd(3'd1, 2'd0, 1'b0);
    cmd(3'd2, 2'd0, 1'b1);
    cmd(3'd4, 2'd0, 1'b0);
    tick(TRP);
    cmd(3'd1, 2'd0, 1'b0);
    chk("R11 reopened after precharge", bank_open[0], 1);
    tick(BL);
    chk("R11 stale auto close never fires", bank_open[0], 1);
    chk("R11 no error raised", cmd_err, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset;
    t_single_pre;
    t_autopre;
    t_nonpersist;
    t_fullpage;
    t_truncate;
    t_errors;
    t_kill;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule